// File: doc/BRIEF.md
# Cartridge bus DMA controller

This block copies bytes between a main-memory (DRAM) port and a cartridge-bus port. Software programs a DRAM address register and a cartridge address register through a small 32-bit register window, then writes one of two length registers. The offset that is written picks the direction. The written value's low 24 bits plus one give the byte count. While the copy runs, a status bit reports busy. At the end a one-cycle interrupt pulse is raised.

When a transfer finishes, the two address registers do not simply move forward by the byte count. The DRAM address is rounded up to the next 8-byte boundary past the copied data. The cartridge address advances only over the first block of the transfer, rounded up to an even number of bytes. That first block is limited by a 128-byte burst and by the 2 KB DRAM row.

When a save-flash mode input is set, a cartridge-to-DRAM transfer that starts inside the first 64 KB of the save region uses a remapped address. In that remap, the low 20 address bits are doubled.

Top module: `cbus_dma`

## Requirements
- R1: Offset 0x00 holds the DRAM address. A write keeps only the bits of mask 0x00FFFFFE, and a read returns the kept value. After reset it reads 0.
- R2: Offset 0x04 holds the cartridge address. A write keeps only the bits of mask 0xFFFFFFFE, and a read returns the kept value. After reset it reads 0.
- R3: Reads of offsets 0x08 and 0x0C always return 0x7F. Offset 0x10 returns busy in bit 0 and zero in every other bit. A write to 0x10 has no effect.
- R4: A write to offset 0x08 starts a DRAM-to-cartridge copy of N = wdata[23:0] + 1 bytes. Byte i is read from DRAM address A+i and written to cartridge address C+i.
- R5: A write to offset 0x0C starts a cartridge-to-DRAM copy of N = wdata[23:0] + 1 bytes. Byte i is read from cartridge address C+i and written to DRAM address A+i.
- R6: Busy is set by the start write and stays set for exactly N+1 cycles (one byte per clock plus one cycle of read latency). `irq_done` is high for exactly one cycle, in the first cycle after busy falls.
- R7: A start write that arrives while busy is ignored: the running transfer's length, data and final addresses are unchanged.
- R8: On completion the DRAM address register becomes (A + N + 7) with bits 2:0 cleared, truncated to 24 bits.
- R9: On completion the cartridge address register becomes C plus K rounded up to even. K = min(N, min(128 - A[2:0], 2048 - A[10:0])).
- R10: A DRAM address at or above the implemented size DRAM_BYTES has two effects. In a DRAM-to-cartridge copy, the cartridge receives 0 for that byte. In a cartridge-to-DRAM copy, no DRAM write is issued for that byte.
- R11: The remap applies when `save_flash_en` is 1 at a 0x0C start and 0x08000000 <= C < 0x08010000. The cartridge register is then first replaced by 0x08000000 | (C[19:0] << 1), and the copy and the R9 update use the new value. The remap applies to no other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_flash_en | input | 1 | Enables the save-region address remap for cartridge-to-DRAM starts |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq_done | output | 1 | One-cycle completion pulse |
| dram_addr | output | 24 | DRAM byte address |
| dram_rd | output | 1 | DRAM read strobe; data returns one cycle later |
| dram_rdata | input | 8 | DRAM read data |
| dram_wr | output | 1 | DRAM write strobe |
| dram_wdata | output | 8 | DRAM write data |
| cart_addr | output | 32 | Cartridge byte address |
| cart_rd | output | 1 | Cartridge read strobe; data returns one cycle later |
| cart_rdata | input | 8 | Cartridge read data |
| cart_wr | output | 1 | Cartridge write strobe |
| cart_wdata | output | 8 | Cartridge write data |

## Verification
Both directions are swept over every DRAM start offset from 0 to 18 (even) and every length from 1 to 20. This covers odd and even block lengths, lengths below and above the misalignment, and every value of A[2:0] that the rounding rules see. Further directed starts isolate the other cases:
- one that crosses a 2 KB row, so the row limit rather than the burst sets K;
- one of 200 bytes, so the 128-byte burst limit sets K;
- transfers that run past the implemented DRAM size, in each direction;
- starts inside, below and at the upper edge of the save region, with the flash mode on and off;
- a second start written mid-transfer.

Source bytes come from address-derived patterns, so a wrong byte, a wrong address or a wrong direction each show up as a data mismatch.

// File: rtl/cbus_dma_pkg.sv
package cbus_dma_pkg;

    typedef enum logic {
        DIR_TO_CART = 1'b0,
        DIR_TO_DRAM = 1'b1
    } xfer_dir_e;

    localparam logic [4:0] OFS_DRAM_ADDR = 5'h00;
    localparam logic [4:0] OFS_CART_ADDR = 5'h04;
    localparam logic [4:0] OFS_GO_CART   = 5'h08;
    localparam logic [4:0] OFS_GO_DRAM   = 5'h0C;
    localparam logic [4:0] OFS_STATUS    = 5'h10;

    localparam logic [31:0] LEN_READ_VALUE = 32'h0000_007F;

endpackage

// File: rtl/cbus_dma_remap.sv
module cbus_dma_remap #(
    parameter logic [31:0] SAVE_BASE   = 32'h0800_0000,
    parameter logic [31:0] SAVE_END    = 32'h0801_0000,
    parameter int          SAVE_KEEP_W = 20
) (
    input  logic        en_i,
    input  logic [31:0] addr_i,
    output logic [31:0] addr_o
);
    logic        hit;
    logic [31:0] doubled;

    always_comb begin
        hit     = en_i && (addr_i >= SAVE_BASE) && (addr_i < SAVE_END);
        doubled = 32'(addr_i[SAVE_KEEP_W-1:0]) << 1;
        addr_o  = hit ? (SAVE_BASE | doubled) : addr_i;
    end
endmodule

// File: rtl/cbus_dma_post.sv
module cbus_dma_post #(
    parameter int DW    = 24,
    parameter int CW    = 32,
    parameter int LW    = 25,
    parameter int BURST = 128,
    parameter int ROW   = 2048,
    parameter int ALIGN = 8
) (
    input  logic [DW-1:0] dram_i,
    input  logic [CW-1:0] cart_i,
    input  logic [LW-1:0] count_i,
    output logic [DW-1:0] dram_o,
    output logic [CW-1:0] cart_o
);
    localparam int ROW_W = $clog2(ROW);
    localparam int AL_W  = $clog2(ALIGN);
    localparam int BK_W  = ROW_W + 1;
    localparam int SW    = ((LW > DW) ? LW : DW) + 2;

    logic [BK_W-1:0] row_left;
    logic [BK_W-1:0] burst_left;
    logic [BK_W-1:0] block;
    logic [LW-1:0]   cur;
    logic [LW-1:0]   cur_even;
    logic [SW-1:0]   sum;

    always_comb begin
        row_left   = BK_W'(ROW) - BK_W'(dram_i[ROW_W-1:0]);
        burst_left = BK_W'(BURST) - BK_W'(dram_i[AL_W-1:0]);
        block      = (burst_left < row_left) ? burst_left : row_left;
        cur        = (count_i < LW'(block)) ? count_i : LW'(block);
        cur_even   = cur + LW'(cur[0]);
        cart_o     = cart_i + CW'(cur_even);
        sum        = SW'(dram_i) + SW'(count_i) + SW'(ALIGN - 1);
        dram_o     = sum[DW-1:0] & ~DW'(ALIGN - 1);
    end
endmodule

// File: rtl/cbus_dma_seq.sv
module cbus_dma_seq
    import cbus_dma_pkg::*;
#(
    parameter int DW         = 24,
    parameter int CW         = 32,
    parameter int LW         = 25,
    parameter int DRAM_BYTES = 4194304
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  xfer_dir_e     dir_i,
    input  logic [DW-1:0] dbase_i,
    input  logic [CW-1:0] cbase_i,
    input  logic [LW-1:0] count_i,
    output logic          busy_o,
    output logic          last_o,
    output logic          done_o,
    output logic [DW-1:0] dram_addr_o,
    output logic          dram_rd_o,
    input  logic [7:0]    dram_rdata_i,
    output logic          dram_wr_o,
    output logic [7:0]    dram_wdata_o,
    output logic [CW-1:0] cart_addr_o,
    output logic          cart_rd_o,
    input  logic [7:0]    cart_rdata_i,
    output logic          cart_wr_o,
    output logic [7:0]    cart_wdata_o
);
    localparam logic [DW:0] DRAM_LIMIT = (DW+1)'(DRAM_BYTES);

    typedef struct packed {
        logic          busy;
        xfer_dir_e     dir;
        logic [DW-1:0] dbase;
        logic [CW-1:0] cbase;
        logic [LW-1:0] count;
        logic [LW-1:0] rd_idx;
        logic          wv;
        logic [LW-1:0] widx;
        logic          done;
    } seq_state_t;

    seq_state_t s_q, s_d;

    logic          rd_go;
    logic          last;
    logic [DW-1:0] rd_daddr;
    logic [DW-1:0] wr_daddr;
    logic          rd_in;
    logic          wr_in;

    always_comb begin
        rd_go    = s_q.busy && (s_q.rd_idx < s_q.count);
        last     = s_q.wv && (s_q.widx == s_q.count - LW'(1));
        rd_daddr = s_q.dbase + DW'(s_q.rd_idx);
        wr_daddr = s_q.dbase + DW'(s_q.widx);
        rd_in    = {1'b0, rd_daddr} < DRAM_LIMIT;
        wr_in    = {1'b0, wr_daddr} < DRAM_LIMIT;

        dram_rd_o    = 1'b0;
        dram_wr_o    = 1'b0;
        cart_rd_o    = 1'b0;
        cart_wr_o    = 1'b0;
        dram_wdata_o = cart_rdata_i;
        cart_wdata_o = wr_in ? dram_rdata_i : 8'h00;
        if (s_q.dir == DIR_TO_CART) begin
            dram_addr_o = rd_daddr;
            cart_addr_o = s_q.cbase + CW'(s_q.widx);
            dram_rd_o   = rd_go && rd_in;
            cart_wr_o   = s_q.wv;
        end else begin
            dram_addr_o = wr_daddr;
            cart_addr_o = s_q.cbase + CW'(s_q.rd_idx);
            cart_rd_o   = rd_go;
            dram_wr_o   = s_q.wv && wr_in;
        end

        s_d      = s_q;
        s_d.done = 1'b0;
        if (rd_go) begin
            s_d.rd_idx = s_q.rd_idx + LW'(1);
            s_d.wv     = 1'b1;
            s_d.widx   = s_q.rd_idx;
        end else begin
            s_d.wv = 1'b0;
        end
        if (last) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
        end
        if (start_i && !s_q.busy) begin
            s_d.busy   = 1'b1;
            s_d.dir    = dir_i;
            s_d.dbase  = dbase_i;
            s_d.cbase  = cbase_i;
            s_d.count  = count_i;
            s_d.rd_idx = '0;
            s_d.wv     = 1'b0;
            s_d.widx   = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign last_o = last;
    assign done_o = s_q.done;

    a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);
    a_r6_busy_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.busy) |-> s_q.done);
    a_r7_count_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && $past(s_q.busy)) |-> $stable(s_q.count));
    a_r4_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cart_wr_o || dram_wr_o) |-> $past(s_q.busy));
    a_r10_dram_wr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dram_wr_o |-> ({1'b0, dram_addr_o} < DRAM_LIMIT));
endmodule

// File: rtl/cbus_dma.sv
module cbus_dma
    import cbus_dma_pkg::*;
#(
    parameter int          DRAM_AW     = 24,
    parameter int          LEN_FW      = 24,
    parameter int          DRAM_BYTES  = 4194304,
    parameter int          BURST       = 128,
    parameter int          ROW         = 2048,
    parameter int          ALIGN       = 8,
    parameter logic [31:0] SAVE_BASE   = 32'h0800_0000,
    parameter logic [31:0] SAVE_END    = 32'h0801_0000,
    parameter int          SAVE_KEEP_W = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               save_flash_en,
    input  logic               reg_wr,
    input  logic [4:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               irq_done,
    output logic [DRAM_AW-1:0] dram_addr,
    output logic               dram_rd,
    input  logic [7:0]         dram_rdata,
    output logic               dram_wr,
    output logic [7:0]         dram_wdata,
    output logic [31:0]        cart_addr,
    output logic               cart_rd,
    input  logic [7:0]         cart_rdata,
    output logic               cart_wr,
    output logic [7:0]         cart_wdata
);
    localparam int DW   = DRAM_AW;
    localparam int LW   = LEN_FW + 1;
    localparam int AL_W = $clog2(ALIGN);
    localparam logic [DW-1:0] DRAM_KEEP = ~DW'(1);
    localparam logic [31:0]   CART_KEEP = ~32'(1);

    typedef struct packed {
        logic [DW-1:0] dram;
        logic [31:0]   cart;
        logic [DW-1:0] pend_dram;
        logic [31:0]   pend_cart;
    } regs_t;

    regs_t r_q, r_d;

    logic          go_cart;
    logic          go_dram;
    logic          start_ok;
    logic [LW-1:0] count;
    logic [31:0]   cart_remapped;
    logic [31:0]   cart_start;
    logic [DW-1:0] post_dram;
    logic [31:0]   post_cart;
    logic          seq_busy;
    logic          seq_last;
    xfer_dir_e     dir;

    cbus_dma_remap #(
        .SAVE_BASE  (SAVE_BASE),
        .SAVE_END   (SAVE_END),
        .SAVE_KEEP_W(SAVE_KEEP_W)
    ) remap_i (
        .en_i  (save_flash_en),
        .addr_i(r_q.cart),
        .addr_o(cart_remapped)
    );

    cbus_dma_post #(
        .DW   (DW),
        .CW   (32),
        .LW   (LW),
        .BURST(BURST),
        .ROW  (ROW),
        .ALIGN(ALIGN)
    ) post_i (
        .dram_i (r_q.dram),
        .cart_i (cart_start),
        .count_i(count),
        .dram_o (post_dram),
        .cart_o (post_cart)
    );

    cbus_dma_seq #(
        .DW        (DW),
        .CW        (32),
        .LW        (LW),
        .DRAM_BYTES(DRAM_BYTES)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_ok),
        .dir_i       (dir),
        .dbase_i     (r_q.dram),
        .cbase_i     (cart_start),
        .count_i     (count),
        .busy_o      (seq_busy),
        .last_o      (seq_last),
        .done_o      (irq_done),
        .dram_addr_o (dram_addr),
        .dram_rd_o   (dram_rd),
        .dram_rdata_i(dram_rdata),
        .dram_wr_o   (dram_wr),
        .dram_wdata_o(dram_wdata),
        .cart_addr_o (cart_addr),
        .cart_rd_o   (cart_rd),
        .cart_rdata_i(cart_rdata),
        .cart_wr_o   (cart_wr),
        .cart_wdata_o(cart_wdata)
    );

    always_comb begin
        go_cart    = reg_wr && (reg_addr == OFS_GO_CART);
        go_dram    = reg_wr && (reg_addr == OFS_GO_DRAM);
        start_ok   = (go_cart || go_dram) && !seq_busy;
        dir        = go_dram ? DIR_TO_DRAM : DIR_TO_CART;
        count      = LW'(reg_wdata[LEN_FW-1:0]) + LW'(1);
        cart_start = go_dram ? cart_remapped : r_q.cart;

        r_d = r_q;
        if (reg_wr && reg_addr == OFS_DRAM_ADDR) r_d.dram = reg_wdata[DW-1:0] & DRAM_KEEP;
        if (reg_wr && reg_addr == OFS_CART_ADDR) r_d.cart = reg_wdata & CART_KEEP;
        if (start_ok) begin
            r_d.cart      = cart_start;
            r_d.pend_dram = post_dram;
            r_d.pend_cart = post_cart;
        end
        if (seq_last) begin
            r_d.dram = r_q.pend_dram;
            r_d.cart = r_q.pend_cart;
        end

        case (reg_addr)
            OFS_DRAM_ADDR: reg_rdata = 32'(r_q.dram);
            OFS_CART_ADDR: reg_rdata = r_q.cart;
            OFS_GO_CART:   reg_rdata = LEN_READ_VALUE;
            OFS_GO_DRAM:   reg_rdata = LEN_READ_VALUE;
            OFS_STATUS:    reg_rdata = {31'b0, seq_busy};
            default:       reg_rdata = 32'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    a_r1_dram_even: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.dram[0] == 1'b0);
    a_r2_cart_even: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cart[0] == 1'b0);
    a_r8_aligned_at_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |-> (r_q.dram[AL_W-1:0] == '0));
    a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_busy && (go_cart || go_dram)) |=> $stable(r_q.pend_cart) && $stable(r_q.pend_dram));
endmodule

// File: tb/cbus_dma_tb_top.sv
module cbus_dma_tb_top;
    localparam int DB = 512;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        save_flash_en;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq_done;
    logic [23:0] dram_addr;
    logic        dram_rd;
    logic [7:0]  dram_rdata;
    logic        dram_wr;
    logic [7:0]  dram_wdata;
    logic [31:0] cart_addr;
    logic        cart_rd;
    logic [7:0]  cart_rdata;
    logic        cart_wr;
    logic [7:0]  cart_wdata;

    int total = 0;
    int bad   = 0;
    int gen   = 0;
    int oob_writes = 0;

    logic [7:0] dw_data [DB];
    int         dw_gen  [DB];
    logic [7:0] cw_data [4096];
    int         cw_gen  [4096];

    always #4 clk = ~clk;

    cbus_dma #(.DRAM_BYTES(DB)) dut_i (
        .clk(clk), .rst_n(rst_n), .save_flash_en(save_flash_en),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_done(irq_done),
        .dram_addr(dram_addr), .dram_rd(dram_rd), .dram_rdata(dram_rdata),
        .dram_wr(dram_wr), .dram_wdata(dram_wdata),
        .cart_addr(cart_addr), .cart_rd(cart_rd), .cart_rdata(cart_rdata),
        .cart_wr(cart_wr), .cart_wdata(cart_wdata)
    );

    function automatic logic [7:0] pat_d(input logic [23:0] a);
        return a[7:0] * 8'd13 + a[15:8] + 8'd7;
    endfunction

    function automatic logic [7:0] pat_c(input logic [31:0] a, input int g);
        return a[7:0] * 8'd29 + a[19:12] + 8'(g * 3) + 8'd91;
    endfunction

    always @(posedge clk) begin
        if (dram_rd) dram_rdata <= pat_d(dram_addr);
        if (cart_rd) cart_rdata <= pat_c(cart_addr, gen);
        if (dram_wr) begin
            if (dram_addr < 24'(DB)) begin
                dw_data[dram_addr[8:0]] <= dram_wdata;
                dw_gen[dram_addr[8:0]]  <= gen;
            end else begin
                oob_writes <= oob_writes + 1;
            end
        end
        if (cart_wr) begin
            cw_data[cart_addr[11:0]] <= cart_wdata;
            cw_gen[cart_addr[11:0]]  <= gen;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Runs one transfer and checks R4/R5/R6/R8/R9/R10/R11 against arithmetic expectations.
    task automatic run(input bit to_dram, input logic [23:0] d, input logic [31:0] c,
                       input int n, input bit flash, input int poke_at);
        logic [31:0] ce, exp_c, v;
        logic [23:0] exp_d;
        int k, blk, busy_cnt, irq_cnt, irq_at, errs, oob0;
        string tag;
        gen++;
        save_flash_en = flash;
        wr_reg(5'h00, 32'(d));
        wr_reg(5'h04, c);
        ce = c;
        if (to_dram && flash && c >= 32'h0800_0000 && c < 32'h0801_0000)
            ce = 32'h0800_0000 | (32'(c[19:0]) << 1);
        blk = 128 - int'(d[2:0]);
        if (2048 - int'(d[10:0]) < blk) blk = 2048 - int'(d[10:0]);
        k = (n < blk) ? n : blk;
        exp_c = ce + 32'((k + 1) & ~1);
        exp_d = 24'((int'(d) + n + 7) & ~7);
        oob0 = oob_writes;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = to_dram ? 5'h0C : 5'h08; reg_wdata = 32'hA500_0000 | 32'(n - 1);
        busy_cnt = 0; irq_cnt = 0; irq_at = -1;
        for (int it = 1; it <= n + 4; it++) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_addr = 5'h10;
            #1;
            if (reg_rdata[0]) busy_cnt++;
            if (irq_done) begin irq_cnt++; irq_at = it; end
            if (it == poke_at) begin
                reg_wr = 1'b1; reg_addr = 5'h08; reg_wdata = 32'h0000_0000;
            end
        end
        tag = to_dram ? "R5" : "R4";
        chk(busy_cnt == n + 1, "R6 busy cycles", 32'(busy_cnt), 32'(n + 1));
        chk(irq_cnt == 1 && irq_at == n + 2, "R6 irq pulse", 32'(irq_at), 32'(n + 2));
        errs = 0;
        for (int i = 0; i < n; i++) begin
            if (to_dram) begin
                if (int'(d) + i < DB) begin
                    if (dw_gen[int'(d) + i] != gen || dw_data[int'(d) + i] != pat_c(ce + 32'(i), gen)) errs++;
                end
            end else begin
                logic [11:0] a;
                logic [7:0]  e;
                a = 12'(ce + 32'(i));
                e = (int'(d) + i < DB) ? pat_d(d + 24'(i)) : 8'h00;
                if (cw_gen[a] != gen || cw_data[a] != e) errs++;
            end
        end
        if (to_dram) begin
            if (int'(d) + n < DB && dw_gen[int'(d) + n] == gen) errs++;
            chk(oob_writes == oob0, "R10 no out-of-range DRAM write", 32'(oob_writes - oob0), 0);
        end else begin
            if (cw_gen[12'(ce + 32'(n))] == gen) errs++;
        end
        chk(errs == 0, {tag, " data bytes"}, 32'(errs), 0);
        rd_reg(5'h00, v);
        chk(v == 32'(exp_d), "R8 dram post-update", v, 32'(exp_d));
        rd_reg(5'h04, v);
        chk(v == exp_c, "R9 cart post-update", v, exp_c);
    endtask

    initial begin
        #(8 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; save_flash_en = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset values
        rd_reg(5'h00, v); chk(v == 0, "R1 reset dram", v, 0);
        rd_reg(5'h04, v); chk(v == 0, "R2 reset cart", v, 0);
        rd_reg(5'h08, v); chk(v == 32'h7F, "R3 len read 08", v, 32'h7F);
        rd_reg(5'h0C, v); chk(v == 32'h7F, "R3 len read 0C", v, 32'h7F);
        rd_reg(5'h10, v); chk(v == 0, "R3 status idle", v, 0);
        chk(irq_done == 1'b0, "R6 irq low at reset", 32'(irq_done), 0);

        // Masks
        wr_reg(5'h00, 32'hFFFF_FFFF);
        rd_reg(5'h00, v); chk(v == 32'h00FF_FFFE, "R1 dram mask", v, 32'h00FF_FFFE);
        wr_reg(5'h04, 32'hFFFF_FFFF);
        rd_reg(5'h04, v); chk(v == 32'hFFFF_FFFE, "R2 cart mask", v, 32'hFFFF_FFFE);
        wr_reg(5'h10, 32'hFFFF_FFFF);
        rd_reg(5'h10, v); chk(v == 0, "R3 status write ignored", v, 0);
        chk(irq_done == 1'b0, "R3 status write starts nothing", 32'(irq_done), 0);

        // Sweeps over DRAM start offset and length, both directions
        for (int dofs = 0; dofs < 20; dofs += 2)
            for (int n = 1; n <= 20; n++)
                run(1'b0, 24'(dofs), 32'h1000_0200 + 32'(dofs * 2), n, 1'b0, -1);
        for (int dofs = 0; dofs < 20; dofs += 2)
            for (int n = 1; n <= 20; n++)
                run(1'b1, 24'(dofs + 64), 32'h1000_0400 + 32'(dofs * 6), n, 1'b1, -1);

        // Row limit sets the block (R9), DRAM beyond implemented size reads as zero (R10)
        run(1'b0, 24'h0007F2, 32'h0000_0100, 40, 1'b0, -1);
        // Burst limit sets the block (R9)
        run(1'b0, 24'h000006, 32'h0000_0300, 200, 1'b0, -1);
        // Cartridge-to-DRAM past the implemented size drops bytes (R10)
        run(1'b1, 24'h0001FA, 32'h0000_0500, 16, 1'b0, -1);
        // Save-region remap (R11): on, off, below and at upper edge
        run(1'b1, 24'h000020, 32'h0800_0010, 9, 1'b1, -1);
        run(1'b1, 24'h000020, 32'h0800_0010, 9, 1'b0, -1);
        run(1'b1, 24'h000040, 32'h0801_0000, 6, 1'b1, -1);
        run(1'b1, 24'h000040, 32'h07FF_FFF0, 6, 1'b1, -1);
        run(1'b1, 24'h000060, 32'h0800_FFFE, 4, 1'b1, -1);
        // DRAM-to-cartridge never remaps (R11)
        run(1'b0, 24'h000020, 32'h0800_0010, 7, 1'b1, -1);
        // Start while busy is ignored (R7)
        run(1'b0, 24'h000010, 32'h0000_0700, 12, 1'b0, 3);
        run(1'b1, 24'h000030, 32'h0000_0800, 12, 1'b0, 5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule